// File: doc/BRIEF.md
# Shifter Operand Generator

This block forms the second source operand of a data-processing operation. It takes the 32-bit operation word, the values already read for the shifted register and the shift-count register, a marker for each of those two registers saying it is the program counter, and the current carry flag. From these it returns the 32-bit operand and the carry bit that the shifter would pass to the flags. The logic is purely combinational.

The operation word selects one of three operand forms: a register shifted by a 5-bit constant, a register shifted by a count held in a second register, or an 8-bit constant rotated by an even amount. Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. Shift amounts of zero and of 32 or more do not follow the plain shift rule. Each of them is decoded into its own defined result, such as rotate through carry, shift by a full word, sign fill, or a rotation by a whole multiple of the word width.

The register-count form reads an extra register port, so the block raises a flag that tells the sequencer to add one cycle. The register file, the ALU and flag writeback sit outside this block.

Top module: `shifter_operand_gen`

## Requirements
- R1: Bit 25 set selects the rotated-constant form. Bit 25 clear with bit 4 clear selects the constant-shift form, whose amount is bits 11:7. Bit 25 clear with bit 4 set selects the register-count form. Bits 6:5 give the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. Bits 31:26 and 24:12 have no effect.
- R2: For a constant shift with a nonzero amount n, the operand is the shifted or rotated register value. The carry is the last bit moved out: bit 32-n for a left shift, and bit n-1 for a right shift or a rotate.
- R3: A constant logical left shift of 0 returns the register unchanged, and the carry equals carry_in.
- R4: A constant logical right shift with amount field 0 acts as a shift by 32: the operand is 0 and the carry is bit 31 of the register.
- R5: A constant arithmetic right shift with amount field 0 fills every operand bit with bit 31 of the register, and the carry is also that bit.
- R6: A constant rotate with amount field 0 rotates right by one through the carry: the operand is {carry_in, value[31:1]} and the carry is value[0].
- R7: In the register-count form, only bits 7:0 of the count register are used. A count of 0 returns the value unchanged with the carry equal to carry_in, for every shift kind.
- R8: In the register-count form, a count from 1 to 31 shifts normally, and the carry is the last bit moved out.
- R9: In the register-count form, a logical shift by exactly 32 gives operand 0. Its carry is value bit 0 for a left shift and value bit 31 for a right shift. A logical shift count above 32 gives operand 0 and carry 0.
- R10: In the register-count form, an arithmetic right shift by 32 or more gives all ones with carry 1 when value bit 31 is set, and 0 with carry 0 otherwise.
- R11: In the register-count form, a rotate uses the low 5 bits of the count. A nonzero count whose low 5 bits are zero returns the value unchanged, with the carry equal to value bit 31.
- R12: In the rotated-constant form, bits 7:0 are rotated right by twice bits 11:8. The carry is carry_in when that rotation is 0, and bit 31 of the operand otherwise.
- R13: In the register-count form only, a register marked as the program counter is read as its value plus 4; a marked count register gets the 4 added before bits 7:0 are taken. extra_cycle is 1 exactly in the register-count form, and both markers have no effect in the other forms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Operation word holding the form, shift kind, amounts and constant |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the register holding the shift count |
| rm_is_pc | input | 1 | The shifted register is the program counter |
| rs_is_pc | input | 1 | The count register is the program counter |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Generated second operand |
| carry_out | output | 1 | Carry produced by the shifter |
| extra_cycle | output | 1 | The register-count form needs one extra cycle |

## Verification
Each shift kind is driven in all three forms with values whose interesting bits are asymmetric, so a shift in the wrong direction or a carry taken from the neighbouring bit gives a different answer. The amounts are chosen around the special points: 0, 1 to 31, exactly 32, just above 32, and large counts whose low bits are zero. Count registers with nonzero upper bits show that only bits 7:0 are used. A count that wraps to zero only after the program-counter offset shows that the offset is added before truncation. Two sweeps over every ordinary count, for logical right shift and for rotate, are compared against a bit-by-bit model built in the bench.

// File: rtl/shop_pkg.sv
package shop_pkg;

    localparam int WORD_W = 32;
    localparam int AMT_W  = 8;
    localparam int IMM_SH = 5;

    // Encoding of bits 6:5 of the operation word
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        OF_IMM_SHIFT = 2'd0,
        OF_REG_SHIFT = 2'd1,
        OF_IMM_ROT   = 2'd2
    } op_form_e;

    // How the final stage builds the result
    typedef enum logic [1:0] {
        SM_PASS  = 2'd0,
        SM_SHIFT = 2'd1,
        SM_RRX   = 2'd2
    } shift_mode_e;

    typedef struct packed {
        op_form_e              form;
        shift_kind_e           kind;
        shift_mode_e           mode;
        logic [AMT_W-1:0]      amount;
    } shift_ctl_t;

endpackage

// File: rtl/shop_decode.sv
module shop_decode
    import shop_pkg::*;
#(
    parameter int PC_ADJ = 4
) (
    input  logic              imm_sel,
    input  logic [11:0]       fld,
    input  logic [AMT_W-1:0]  rs_low,
    input  logic              rs_is_pc,
    output shift_ctl_t        ctl,
    output logic              extra_cycle
);

    localparam logic [AMT_W-1:0] FULL_WORD = AMT_W'(WORD_W);

    logic [AMT_W-1:0]  reg_amt;
    logic [IMM_SH-1:0] imm_amt;
    logic [3:0]        rot_fld;
    shift_kind_e       kind_fld;

    always_comb begin
        reg_amt  = rs_low + (rs_is_pc ? AMT_W'(PC_ADJ) : '0);
        imm_amt  = fld[11:7];
        rot_fld  = fld[11:8];
        kind_fld = shift_kind_e'(fld[6:5]);
    end

    always_comb begin
        ctl         = '0;
        extra_cycle = 1'b0;
        if (imm_sel) begin
            ctl.form   = OF_IMM_ROT;
            ctl.kind   = SK_ROR;
            ctl.amount = AMT_W'({rot_fld, 1'b0});
            ctl.mode   = (rot_fld == 4'd0) ? SM_PASS : SM_SHIFT;
        end else if (fld[4]) begin
            ctl.form    = OF_REG_SHIFT;
            ctl.kind    = kind_fld;
            extra_cycle = 1'b1;
            if (reg_amt == '0) begin
                ctl.mode   = SM_PASS;
                ctl.amount = '0;
            end else begin
                ctl.mode = SM_SHIFT;
                if (kind_fld == SK_ROR) begin
                    ctl.amount = (reg_amt[IMM_SH-1:0] == '0)
                               ? FULL_WORD
                               : AMT_W'(reg_amt[IMM_SH-1:0]);
                end else begin
                    ctl.amount = reg_amt;
                end
            end
        end else begin
            ctl.form = OF_IMM_SHIFT;
            ctl.kind = kind_fld;
            unique case (kind_fld)
                SK_LSL: begin
                    ctl.mode   = (imm_amt == '0) ? SM_PASS : SM_SHIFT;
                    ctl.amount = AMT_W'(imm_amt);
                end
                SK_LSR, SK_ASR: begin
                    ctl.mode   = SM_SHIFT;
                    ctl.amount = (imm_amt == '0) ? FULL_WORD : AMT_W'(imm_amt);
                end
                SK_ROR: begin
                    ctl.mode   = (imm_amt == '0) ? SM_RRX : SM_SHIFT;
                    ctl.amount = AMT_W'(imm_amt);
                end
            endcase
        end
    end

endmodule

// File: rtl/shop_opsel.sv
module shop_opsel
    import shop_pkg::*;
#(
    parameter int PC_ADJ = 4
) (
    input  op_form_e           form,
    input  logic [WORD_W-1:0]  rm_val,
    input  logic               rm_is_pc,
    input  logic [7:0]         imm8,
    output logic [WORD_W-1:0]  value
);

    always_comb begin
        unique case (form)
            OF_IMM_ROT:   value = WORD_W'(imm8);
            OF_REG_SHIFT: value = rm_is_pc ? rm_val + WORD_W'(PC_ADJ) : rm_val;
            default:      value = rm_val;
        endcase
    end

endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
    import shop_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0]      val,
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amount,
    output logic [W-1:0]      res,
    output logic              cout
);

    logic [W:0]        lsl_v;
    logic [W:0]        lsr_v;
    logic signed [W:0] asr_v;
    logic [W-1:0]      ror_v;

    // One guard bit beside the word catches the last bit moved out
    always_comb begin
        lsl_v = {1'b0, val} << amount;
        lsr_v = {val, 1'b0} >> amount;
        asr_v = $signed({val, 1'b0}) >>> amount;
        ror_v = (val >> amount) | (val << (AMT_W'(W) - amount));
    end

    always_comb begin
        unique case (kind)
            SK_LSL: begin res = lsl_v[W-1:0];  cout = lsl_v[W]; end
            SK_LSR: begin res = lsr_v[W:1];    cout = lsr_v[0]; end
            SK_ASR: begin res = asr_v[W:1];    cout = asr_v[0]; end
            SK_ROR: begin res = ror_v;         cout = ror_v[W-1]; end
        endcase
    end

endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
    import shop_pkg::*;
#(
    parameter int PC_ADJ = 4
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] rm_val,
    input  logic [WORD_W-1:0] rs_val,
    input  logic              rm_is_pc,
    input  logic              rs_is_pc,
    input  logic              carry_in,
    output logic [WORD_W-1:0] operand,
    output logic              carry_out,
    output logic              extra_cycle
);

    shift_ctl_t        ctl;
    logic [WORD_W-1:0] src_val;
    logic [WORD_W-1:0] core_res;
    logic              core_c;
    logic              unused_bits;

    assign unused_bits = ^{instr[31:26], instr[24:12], rs_val[WORD_W-1:AMT_W]};

    shop_decode #(.PC_ADJ(PC_ADJ)) u_decode (
        .imm_sel     (instr[25]),
        .fld         (instr[11:0]),
        .rs_low      (rs_val[AMT_W-1:0]),
        .rs_is_pc    (rs_is_pc),
        .ctl         (ctl),
        .extra_cycle (extra_cycle)
    );

    shop_opsel #(.PC_ADJ(PC_ADJ)) u_opsel (
        .form     (ctl.form),
        .rm_val   (rm_val),
        .rm_is_pc (rm_is_pc),
        .imm8     (instr[7:0]),
        .value    (src_val)
    );

    shop_shift_core #(.W(WORD_W)) u_core (
        .val    (src_val),
        .kind   (ctl.kind),
        .amount (ctl.amount),
        .res    (core_res),
        .cout   (core_c)
    );

    always_comb begin
        unique case (ctl.mode)
            SM_PASS: begin
                operand   = src_val;
                carry_out = carry_in;
            end
            SM_RRX: begin
                operand   = {carry_in, src_val[WORD_W-1:1]};
                carry_out = src_val[0];
            end
            default: begin
                operand   = core_res;
                carry_out = core_c;
            end
        endcase
    end

    always_comb begin
        // R3
        if (!instr[25] && !instr[4] && instr[6:5] == 2'b00 && instr[11:7] == 5'd0)
            lsl_zero_chk: assert (operand == rm_val && carry_out == carry_in);
        // R6
        if (!instr[25] && !instr[4] && instr[6:5] == 2'b11 && instr[11:7] == 5'd0)
            rrx_fill_chk: assert (operand[WORD_W-1] == carry_in && carry_out == rm_val[0]);
        // R12
        if (instr[25] && instr[11:8] == 4'd0)
            rot_zero_chk: assert (operand == WORD_W'(instr[7:0]) && carry_out == carry_in);
        // R9
        if (ctl.form == OF_REG_SHIFT && (ctl.kind == SK_LSL || ctl.kind == SK_LSR)
            && ctl.amount > AMT_W'(WORD_W))
            big_shift_chk: assert (operand == '0 && !carry_out);
        // R10
        if (ctl.form == OF_REG_SHIFT && ctl.kind == SK_ASR && ctl.amount >= AMT_W'(WORD_W))
            asr_fill_chk: assert ((operand == '0 || operand == '1) && carry_out == operand[0]);
        // R13
        extra_form_chk: assert (!(extra_cycle && instr[25]));
    end

endmodule

// File: tb/shifter_operand_gen_bench.sv
module shifter_operand_gen_bench;

    typedef struct packed {
        logic [1:0]  form;   // 0 constant shift, 1 register count, 2 rotated constant
        logic [1:0]  kind;
        logic [4:0]  amt;
        logic [3:0]  rot;
        logic [7:0]  imm8;
        logic [31:0] rm;
        logic [31:0] rs;
        logic        rm_pc;
        logic        rs_pc;
        logic        cin;
        logic [31:0] exp_op;
        logic        exp_c;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        // R2
        '{2'd0,2'd0,5'd4,4'd0,8'h00,32'h1000000F,32'h0,1'b0,1'b0,1'b0,32'h000000F0,1'b1,8'd2},
        // R1
        '{2'd0,2'd1,5'd8,4'd0,8'h00,32'h12345680,32'h0,1'b0,1'b0,1'b0,32'h00123456,1'b1,8'd1},
        '{2'd0,2'd2,5'd4,4'd0,8'h00,32'h80000018,32'h0,1'b0,1'b0,1'b0,32'hF8000001,1'b1,8'd2},
        '{2'd0,2'd3,5'd8,4'd0,8'h00,32'h12345678,32'h0,1'b0,1'b0,1'b1,32'h78123456,1'b0,8'd2},
        // R3
        '{2'd0,2'd0,5'd0,4'd0,8'h00,32'hDEADBEEF,32'h0,1'b0,1'b0,1'b1,32'hDEADBEEF,1'b1,8'd3},
        // R4
        '{2'd0,2'd1,5'd0,4'd0,8'h00,32'h80000001,32'h0,1'b0,1'b0,1'b0,32'h00000000,1'b1,8'd4},
        // R5
        '{2'd0,2'd2,5'd0,4'd0,8'h00,32'h80000000,32'h0,1'b0,1'b0,1'b0,32'hFFFFFFFF,1'b1,8'd5},
        '{2'd0,2'd2,5'd0,4'd0,8'h00,32'h7FFFFFFF,32'h0,1'b0,1'b0,1'b1,32'h00000000,1'b0,8'd5},
        // R6
        '{2'd0,2'd3,5'd0,4'd0,8'h00,32'h00000003,32'h0,1'b0,1'b0,1'b1,32'h80000001,1'b1,8'd6},
        '{2'd0,2'd3,5'd0,4'd0,8'h00,32'h80000002,32'h0,1'b0,1'b0,1'b0,32'h40000001,1'b0,8'd6},
        // R7
        '{2'd1,2'd1,5'd0,4'd0,8'h00,32'hCAFEF00D,32'h00000100,1'b0,1'b0,1'b1,32'hCAFEF00D,1'b1,8'd7},
        // R8
        '{2'd1,2'd0,5'd0,4'd0,8'h00,32'h10000001,32'hFFFFFF04,1'b0,1'b0,1'b0,32'h00000010,1'b1,8'd8},
        '{2'd1,2'd2,5'd0,4'd0,8'h00,32'h80000010,32'h00000003,1'b0,1'b0,1'b1,32'hF0000002,1'b0,8'd8},
        // R9
        '{2'd1,2'd0,5'd0,4'd0,8'h00,32'h00000001,32'h00000020,1'b0,1'b0,1'b0,32'h00000000,1'b1,8'd9},
        '{2'd1,2'd1,5'd0,4'd0,8'h00,32'h80000000,32'h00000020,1'b0,1'b0,1'b0,32'h00000000,1'b1,8'd9},
        '{2'd1,2'd0,5'd0,4'd0,8'h00,32'hFFFFFFFF,32'h00000021,1'b0,1'b0,1'b1,32'h00000000,1'b0,8'd9},
        '{2'd1,2'd1,5'd0,4'd0,8'h00,32'hFFFFFFFF,32'h000000C8,1'b0,1'b0,1'b1,32'h00000000,1'b0,8'd9},
        // R10
        '{2'd1,2'd2,5'd0,4'd0,8'h00,32'h80000000,32'h00000028,1'b0,1'b0,1'b0,32'hFFFFFFFF,1'b1,8'd10},
        '{2'd1,2'd2,5'd0,4'd0,8'h00,32'h40000000,32'h00000020,1'b0,1'b0,1'b1,32'h00000000,1'b0,8'd10},
        // R11
        '{2'd1,2'd3,5'd0,4'd0,8'h00,32'h80000001,32'h00000040,1'b0,1'b0,1'b0,32'h80000001,1'b1,8'd11},
        '{2'd1,2'd3,5'd0,4'd0,8'h00,32'h0000001F,32'h00000024,1'b0,1'b0,1'b0,32'hF0000001,1'b1,8'd11},
        '{2'd1,2'd3,5'd0,4'd0,8'h00,32'h55AA55AA,32'h00000000,1'b0,1'b0,1'b0,32'h55AA55AA,1'b0,8'd7},
        // R12
        '{2'd2,2'd0,5'd0,4'd0,8'hAB,32'hFFFFFFFF,32'h0,1'b0,1'b0,1'b1,32'h000000AB,1'b1,8'd12},
        '{2'd2,2'd0,5'd0,4'd4,8'hFF,32'h0,32'h0,1'b0,1'b0,1'b0,32'hFF000000,1'b1,8'd12},
        '{2'd2,2'd0,5'd0,4'd1,8'h02,32'h0,32'h0,1'b0,1'b0,1'b0,32'h80000000,1'b1,8'd12},
        '{2'd2,2'd0,5'd0,4'd15,8'h01,32'h0,32'h0,1'b1,1'b1,1'b1,32'h00000004,1'b0,8'd12},
        // R13
        '{2'd1,2'd0,5'd0,4'd0,8'h00,32'h00001000,32'h00000001,1'b1,1'b0,1'b1,32'h00002008,1'b0,8'd13},
        '{2'd1,2'd2,5'd0,4'd0,8'h00,32'h00001234,32'h000000FC,1'b0,1'b1,1'b1,32'h00001234,1'b1,8'd13},
        '{2'd0,2'd0,5'd1,4'd0,8'h00,32'h00000010,32'h0,1'b1,1'b1,1'b0,32'h00000020,1'b0,8'd13}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        rm_is_pc = 1'b0;
    logic        rs_is_pc = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;
    logic        extra_cycle;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shifter_operand_gen u_shifter_operand_gen (
        .instr       (instr),
        .rm_val      (rm_val),
        .rs_val      (rs_val),
        .rm_is_pc    (rm_is_pc),
        .rs_is_pc    (rs_is_pc),
        .carry_in    (carry_in),
        .operand     (operand),
        .carry_out   (carry_out),
        .extra_cycle (extra_cycle)
    );

    function automatic logic [31:0] build_instr(logic [1:0] form, logic [1:0] kind,
                                                logic [4:0] amt, logic [3:0] rot,
                                                logic [7:0] imm8);
        logic [31:0] w;
        w = 32'hE1A2_1000;
        if (form == 2'd0)      w[11:0] = {amt, kind, 1'b0, 4'h3};
        else if (form == 2'd1) w[11:0] = {4'h5, 1'b0, kind, 1'b1, 4'h3};
        else begin
            w[25]   = 1'b1;
            w[11:0] = {rot, imm8};
        end
        return w;
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] ins, logic [31:0] rm, logic [31:0] rs,
                         logic rmp, logic rsp, logic c);
        @(negedge clk);
        instr    = ins;
        rm_val   = rm;
        rs_val   = rs;
        rm_is_pc = rmp;
        rs_is_pc = rsp;
        carry_in = c;
        #5;
    endtask

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // quiet state during reset: all-zero inputs select a constant left shift by 0 (R3)
        #5;
        check("R3 idle operand", operand, 32'h0);
        check("R3 idle carry", {31'b0, carry_out}, 32'h0);
        check("R13 idle extra_cycle", {31'b0, extra_cycle}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            apply(build_instr(v.form, v.kind, v.amt, v.rot, v.imm8),
                  v.rm, v.rs, v.rm_pc, v.rs_pc, v.cin);
            check($sformatf("R%0d row %0d operand", v.req, i), operand, v.exp_op);
            check($sformatf("R%0d row %0d carry", v.req, i), {31'b0, carry_out}, {31'b0, v.exp_c});
            check($sformatf("R13 row %0d extra_cycle", i), {31'b0, extra_cycle},
                  {31'b0, (v.form == 2'd1)});
        end

        // R8 sweep: logical right by register count 1..31, bit-serial model
        for (int s = 1; s < 32; s++) begin
            logic [31:0] m;
            logic        c;
            m = 32'h89AB_CDEF;
            c = 1'b0;
            for (int k = 0; k < s; k++) begin
                c = m[0];
                m = {1'b0, m[31:1]};
            end
            apply(build_instr(2'd1, 2'd1, 5'd0, 4'd0, 8'h00), 32'h89AB_CDEF,
                  32'h0000_0000 | s, 1'b0, 1'b0, 1'b1);
            check($sformatf("R8 lsr sweep %0d operand", s), operand, m);
            check($sformatf("R8 lsr sweep %0d carry", s), {31'b0, carry_out}, {31'b0, c});
        end

        // R11 sweep: rotate by register count 1..31 (upper count bits set), bit-serial model
        for (int s = 1; s < 32; s++) begin
            logic [31:0] m;
            logic        c;
            m = 32'h0F1E_2D3C;
            c = 1'b0;
            for (int k = 0; k < s; k++) begin
                c = m[0];
                m = {m[0], m[31:1]};
            end
            apply(build_instr(2'd1, 2'd3, 5'd0, 4'd0, 8'h00), 32'h0F1E_2D3C,
                  32'h0000_00E0 | s, 1'b0, 1'b0, 1'b0);
            check($sformatf("R11 ror sweep %0d operand", s), operand, m);
            check($sformatf("R11 ror sweep %0d carry", s), {31'b0, carry_out}, {31'b0, c});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule